// File: doc/BRIEF.md
# Segment LCD Drive-Level Sequencer

This block produces the drive level of every common and segment electrode of a directly driven segment LCD. It runs in two modes: a static mode with a single common, and a two-common mode at 1/2 duty with 1/2 bias. An oscillator tick input advances a frame divider whose length is picked by a 3-bit code. The divider steps a four-phase sequencer. From the current phase, the display image and the mode fields, the block computes a 2-bit level code for each output pin. A separate analog stage turns these codes into voltages.

Several fields override the plain waveform. A blank field forces every segment to its off waveform. A power-save field stops the divider and pulls commons and segments low. An active-low inhibit input pulls every output low, stops the divider and takes away any port function. A port-select field hands the lowest one to four segment pins over to static general-purpose outputs. In static mode these outputs copy display bit k. In two-common mode they copy bit 2k-1.

The output levels are a combinational function of the registered phase and the current inputs. Because of this, overrides act in the same cycle as their input.

Top module: `lcd_wave_seq`

## Requirements
- R1: During and right after reset the sequencer is at phase 0 with an empty tick count, so in static mode with inhibit high and power save low, common 1 reads high (level code 2'b10) and common 2 reads low.
- R2: Each accepted tick advances a quarter counter. A quarter lasts 192, 144, 96, 72 or 48 ticks for `fc_i` = 3'b110, 3'b111, 3'b000, 3'b001, 3'b010, and 96 ticks for any other code, so a full frame is four quarters. If the setting is shortened while the count is already at or past the new limit, the next tick ends the quarter.
- R3: With `dt_i`=0 (static), common 1 is high in quarters 0 and 1 and low in quarters 2 and 3, and common 2 stays low.
- R4: With `dt_i`=1 (two-common), quarters 0..3 drive: common 1 high, common 2 high, common 1 low, common 2 low. The common that is not named is at mid (code 2'b01).
- R5: In static mode, segment n (1-based, bits [2n-1:2n-2] of `seg_o`) reads display bit n (`disp_i[n-1]`). An off segment drives the same level as common 1, and an on segment drives the opposite of it.
- R6: In two-common mode, segment n reads `disp_i[2n-2]` while common 1 is the driven common and `disp_i[2n-1]` while common 2 is. It drives the opposite of the driven common's level when that bit is 1 and the same level when it is 0.
- R7: With `sc_i`=1, every segment pin that is not a port outputs the off waveform (same level as the driven common).
- R8: With `bu_i`=1, ticks are ignored and the divider is cleared to phase 0, and all commons and segments read low. Pins selected as ports keep driving their data.
- R9: With `inh_ni`=0, every common and segment pin reads low, the port function is dropped, and the divider is cleared to phase 0.
- R10: `pmux_i` = 0..4 turns that many pins, starting at segment 1, into ports, and values 5..7 select none. A port pin k drives high when its bit is 1 and low when it is 0; that bit is `disp_i[k-1]` in static mode and `disp_i[2k-2]` in two-common mode.
- R11: Level codes are 2'b00 low, 2'b01 mid and 2'b10 high. Code 2'b11 never appears on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oscillator tick, one clock wide |
| inh_ni | input | 1 | Display inhibit, active low |
| dt_i | input | 1 | 0 static, 1 two-common 1/2 duty |
| fc_i | input | 3 | Frame length select |
| sc_i | input | 1 | Blank: all segments off |
| bu_i | input | 1 | Power save |
| pmux_i | input | 3 | Number of low pins used as ports |
| disp_i | input | 2*NUM_SEG | Display image, bit i is dot i+1 |
| com_o | output | 4 | Common levels, [1:0] common 1, [3:2] common 2 |
| seg_o | output | 2*NUM_SEG | Segment levels, two bits per pin |

## Verification
A wrong phase count shows at the ports within one quarter. A common edge arrives early or late, and the measured frame length for that code is wrong. In two-common mode the mid level sits on the wrong common. A wrong dot-bit selection or polarity shows on the next cycle as a segment level that disagrees with the driven common. Override and port-mux errors show in the same cycle the field is applied, because these paths carry no register.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  localparam logic [1:0] LVL_LOW  = 2'b00;
  localparam logic [1:0] LVL_MID  = 2'b01;
  localparam logic [1:0] LVL_HIGH = 2'b10;

  // quarter-frame length in units of QUNIT ticks
  function automatic logic [3:0] fc_mult(input logic [2:0] fc);
    case (fc)
      3'b110:  return 4'd8;
      3'b111:  return 4'd6;
      3'b001:  return 4'd3;
      3'b010:  return 4'd2;
      default: return 4'd4;
    endcase
  endfunction

  function automatic logic [1:0] lvl_flip(input logic [1:0] l);
    return (l == LVL_HIGH) ? LVL_LOW : LVL_HIGH;
  endfunction
endpackage

// File: rtl/lcd_frame_div.sv
module lcd_frame_div
  import lcd_seq_pkg::*;
#(
  parameter int QUNIT = 24
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       tick_i,
  input  logic [2:0] fc_i,
  output logic [1:0] phase_o
);
  localparam int CW = $clog2(QUNIT * 8);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  always_comb last = CW'(QUNIT * int'(fc_mult(fc_i)) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_o <= '0;
    end else if (!run_i) begin
      cnt_q   <= '0;
      phase_o <= '0;
    end else if (tick_i) begin
      if (cnt_q >= last) begin
        cnt_q   <= '0;
        phase_o <= phase_o + 2'd1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lcd_com_gen.sv
module lcd_com_gen
  import lcd_seq_pkg::*;
(
  input  logic       dt_i,
  input  logic       active_i,
  input  logic [1:0] phase_i,
  output logic [1:0] com1_o,
  output logic [1:0] com2_o
);
  logic [1:0] drv_lvl;

  assign drv_lvl = phase_i[1] ? LVL_LOW : LVL_HIGH;

  always_comb begin
    com1_o = LVL_LOW;
    com2_o = LVL_LOW;
    if (active_i) begin
      if (!dt_i) begin
        com1_o = drv_lvl;
      end else if (!phase_i[0]) begin
        com1_o = drv_lvl;
        com2_o = LVL_MID;
      end else begin
        com1_o = LVL_MID;
        com2_o = drv_lvl;
      end
    end
  end
endmodule

// File: rtl/lcd_seg_gen.sv
module lcd_seg_gen
  import lcd_seq_pkg::*;
#(
  parameter int NUM_SEG = 54
) (
  input  logic [2*NUM_SEG-1:0]     disp_i,
  input  logic                     dt_i,
  input  logic                     sc_i,
  input  logic                     active_i,
  input  logic [1:0]               phase_i,
  output logic [NUM_SEG-1:0][1:0]  lvl_o
);
  // level of the common being driven this quarter (common 1 in static mode)
  logic [1:0] ref_lvl;
  assign ref_lvl = phase_i[1] ? LVL_LOW : LVL_HIGH;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic dot;
    logic lit;
    always_comb begin
      if (dt_i) dot = phase_i[0] ? disp_i[2*g+1] : disp_i[2*g];
      else      dot = disp_i[g];
      lit = dot & ~sc_i;
      if (!active_i) lvl_o[g] = LVL_LOW;
      else           lvl_o[g] = lit ? lvl_flip(ref_lvl) : ref_lvl;
    end
  end
endmodule

// File: rtl/lcd_port_mux.sv
module lcd_port_mux
  import lcd_seq_pkg::*;
#(
  parameter int NUM_SEG  = 54,
  parameter int GPO_PINS = 4
) (
  input  logic [2:0]               pmux_i,
  input  logic                     dt_i,
  input  logic                     inh_ni,
  input  logic [2*NUM_SEG-1:0]     disp_i,
  input  logic [NUM_SEG-1:0][1:0]  seg_lvl_i,
  output logic [2*NUM_SEG-1:0]     seg_o
);
  logic [2:0] gpo_cnt;
  assign gpo_cnt = (int'(pmux_i) <= GPO_PINS) ? pmux_i : 3'd0;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_pin
    if (g < GPO_PINS) begin : g_port
      logic gpo_en;
      logic bit_v;
      assign gpo_en = inh_ni && (int'(gpo_cnt) > g);
      assign bit_v  = dt_i ? disp_i[2*g] : disp_i[g];
      assign seg_o[2*g+:2] = gpo_en ? (bit_v ? LVL_HIGH : LVL_LOW) : seg_lvl_i[g];
    end else begin : g_plain
      assign seg_o[2*g+:2] = seg_lvl_i[g];
    end
  end
endmodule

// File: rtl/lcd_wave_seq.sv
module lcd_wave_seq
  import lcd_seq_pkg::*;
#(
  parameter int NUM_SEG  = 54,
  parameter int GPO_PINS = 4,
  parameter int QUNIT    = 24
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tick_i,
  input  logic                   inh_ni,
  input  logic                   dt_i,
  input  logic [2:0]             fc_i,
  input  logic                   sc_i,
  input  logic                   bu_i,
  input  logic [2:0]             pmux_i,
  input  logic [2*NUM_SEG-1:0]   disp_i,
  output logic [3:0]             com_o,
  output logic [2*NUM_SEG-1:0]   seg_o
);
  logic                    active;
  logic [1:0]              phase;
  logic [NUM_SEG-1:0][1:0] seg_lvl;

  assign active = inh_ni & ~bu_i;

  lcd_frame_div #(.QUNIT(QUNIT)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (active),
    .tick_i (tick_i),
    .fc_i   (fc_i),
    .phase_o(phase)
  );

  lcd_com_gen u_com (
    .dt_i    (dt_i),
    .active_i(active),
    .phase_i (phase),
    .com1_o  (com_o[1:0]),
    .com2_o  (com_o[3:2])
  );

  lcd_seg_gen #(.NUM_SEG(NUM_SEG)) u_seg (
    .disp_i  (disp_i),
    .dt_i    (dt_i),
    .sc_i    (sc_i),
    .active_i(active),
    .phase_i (phase),
    .lvl_o   (seg_lvl)
  );

  lcd_port_mux #(.NUM_SEG(NUM_SEG), .GPO_PINS(GPO_PINS)) u_mux (
    .pmux_i   (pmux_i),
    .dt_i     (dt_i),
    .inh_ni   (inh_ni),
    .disp_i   (disp_i),
    .seg_lvl_i(seg_lvl),
    .seg_o    (seg_o)
  );
endmodule

// File: rtl/lcd_wave_seq_chk.sv
module lcd_wave_seq_chk
  import lcd_seq_pkg::*;
#(
  parameter int NUM_SEG = 54
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 inh_ni,
  input logic                 dt_i,
  input logic                 sc_i,
  input logic                 bu_i,
  input logic [3:0]           com_o,
  input logic [2*NUM_SEG-1:0] seg_o
);
  logic       bad_code;
  logic [1:0] drv_com;
  logic [1:0] top_seg;

  always_comb begin
    bad_code = (com_o[1:0] == 2'b11) || (com_o[3:2] == 2'b11);
    for (int i = 0; i < NUM_SEG; i++)
      if (seg_o[2*i+:2] == 2'b11) bad_code = 1'b1;
  end

  assign drv_com = (com_o[1:0] == LVL_MID) ? com_o[3:2] : com_o[1:0];
  assign top_seg = seg_o[2*NUM_SEG-1 -: 2];

  assert_no_bad_code_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bad_code);

  assert_inhibit_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inh_ni |-> (com_o == '0 && seg_o[2*NUM_SEG-1:8] == '0));

  assert_save_com_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inh_ni && bu_i) |-> (com_o == '0 && top_seg == LVL_LOW));

  assert_static_com_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inh_ni && !bu_i && !dt_i) |-> (com_o[3:2] == LVL_LOW && com_o[1:0] != LVL_MID));

  assert_one_driven_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inh_ni && !bu_i && dt_i) |-> ((com_o[1:0] == LVL_MID) != (com_o[3:2] == LVL_MID)));

  assert_blank_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inh_ni && !bu_i && sc_i) |-> (top_seg == drv_com));
endmodule

bind lcd_wave_seq lcd_wave_seq_chk #(.NUM_SEG(NUM_SEG)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .inh_ni(inh_ni),
  .dt_i  (dt_i),
  .sc_i  (sc_i),
  .bu_i  (bu_i),
  .com_o (com_o),
  .seg_o (seg_o)
);

// File: tb/sim_lcd_wave_seq.sv
`timescale 1ns/1ps
module sim_lcd_wave_seq;
  localparam int NS = 54;
  localparam int DW = 2 * NS;
  localparam logic [1:0] L = 2'b00, M = 2'b01, H = 2'b10;

  logic clk = 0, rst_n = 0, tick = 0, inh_n = 1, dt = 0, sc = 0, bu = 0;
  logic [2:0] fc = 3'b000, pm = 3'd0;
  logic [DW-1:0] disp = '0;
  logic [3:0] com;
  logic [DW-1:0] seg;

  int n_tests = 0, n_fail = 0;
  int m_cnt = 0, m_ph = 0;

  always #10 clk = ~clk;

  lcd_wave_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .inh_ni(inh_n), .dt_i(dt),
    .fc_i(fc), .sc_i(sc), .bu_i(bu), .pmux_i(pm), .disp_i(disp),
    .com_o(com), .seg_o(seg)
  );

  function automatic int quarter_len(logic [2:0] f);
    case (f)
      3'b110:  return 192;
      3'b111:  return 144;
      3'b001:  return 72;
      3'b010:  return 48;
      default: return 96;
    endcase
  endfunction

  function automatic logic [1:0] inv(logic [1:0] l);
    return (l == H) ? L : H;
  endfunction

  // reference phase model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_ph = 0;
    end else if (!inh_n || bu) begin
      m_cnt = 0; m_ph = 0;
    end else if (tick) begin
      if (m_cnt >= quarter_len(fc) - 1) begin
        m_cnt = 0; m_ph = (m_ph + 1) % 4;
      end else m_cnt++;
    end
  end

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [1:0] drv, c1, c2;
    logic [DW-1:0] e_seg;
    int ports;
    bit dot, bad;
    string stag, ctag;
    drv = (m_ph < 2) ? H : L;
    c1 = L; c2 = L;
    ports = (pm <= 4) ? int'(pm) : 0;
    if (inh_n && !bu) begin
      if (!dt) c1 = drv;
      else if (m_ph % 2 == 0) begin c1 = drv; c2 = M; end
      else begin c1 = M; c2 = drv; end
    end
    for (int n = 1; n <= NS; n++) begin
      if (dt) dot = (m_ph % 2 == 0) ? disp[2*n-2] : disp[2*n-1];
      else    dot = disp[n-1];
      if (!inh_n || bu) e_seg[2*n-2 +: 2] = L;
      else e_seg[2*n-2 +: 2] = (dot && !sc) ? inv(drv) : drv;
      if (inh_n && n <= ports)
        e_seg[2*n-2 +: 2] = (dt ? disp[2*n-2] : disp[n-1]) ? H : L;
    end
    if (!inh_n) begin ctag = "R9"; stag = "R9"; end
    else if (bu) begin ctag = "R8"; stag = "R8"; end
    else begin
      ctag = dt ? "R4" : "R3";
      stag = sc ? "R7" : (dt ? "R6" : "R5");
    end
    if (rst_n) begin
      check(ctag, DW'(com), DW'({c2, c1}));
      check(stag, DW'(seg[DW-1:8]), DW'(e_seg[DW-1:8]));
      check((inh_n && ports > 0) ? "R10" : stag, DW'(seg[7:0]), DW'(e_seg[7:0]));
      bad = (com[1:0] == 2'b11) || (com[3:2] == 2'b11);
      for (int i = 0; i < NS; i++) if (seg[2*i +: 2] == 2'b11) bad = 1;
      check("R11", DW'(bad), '0);
    end
  end

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // counts cycles between consecutive common-1 rises in static mode
  task automatic measure(logic [2:0] f, int exp_frame);
    logic [1:0] prev;
    int cnt;
    @(posedge clk); #1 fc = f;
    prev = com[1:0];
    forever begin
      @(negedge clk);
      if (prev != H && com[1:0] == H) break;
      prev = com[1:0];
    end
    cnt = 0;
    prev = com[1:0];
    forever begin
      @(negedge clk);
      cnt++;
      if (prev != H && com[1:0] == H) break;
      prev = com[1:0];
    end
    check("R2", DW'(cnt), DW'(exp_frame));
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    cycles(2);
    @(negedge clk);
    check("R1", DW'(com), DW'({L, H}));
    @(posedge clk); #1 rst_n = 1; tick = 1;
    disp = {$urandom, $urandom, $urandom, $urandom};
    cycles(5);
    @(negedge clk);
    check("R1", DW'(com), DW'({L, H}));
    cycles(800);
    // frame lengths
    measure(3'b110, 768);
    measure(3'b111, 576);
    measure(3'b000, 384);
    measure(3'b001, 288);
    measure(3'b010, 192);
    measure(3'b101, 384);
    // shorten mid-quarter
    fc = 3'b110; cycles(150); fc = 3'b010; cycles(300);
    // two-common mode
    dt = 1;
    for (int i = 0; i < 6; i++) begin
      disp = {$urandom, $urandom, $urandom, $urandom};
      cycles(100);
    end
    sc = 1; cycles(250); sc = 0;
    disp = '1; cycles(200); disp = '0; cycles(200);
    // sparse ticks
    fc = 3'b000;
    for (int i = 0; i < 900; i++) begin
      @(posedge clk); #1 tick = (i % 3 == 0);
    end
    tick = 1;
    // port select in both modes
    disp = {$urandom, $urandom, $urandom, $urandom};
    for (int d = 0; d < 2; d++) begin
      dt = d[0];
      for (int p = 0; p < 8; p++) begin
        pm = 3'(p);
        cycles(120);
        disp[7:0] = ~disp[7:0];
        cycles(80);
      end
    end
    // power save with ports
    pm = 3'd3; dt = 0; bu = 1; cycles(300);
    disp[3:0] = 4'b1010; cycles(50);
    bu = 0; cycles(500);
    dt = 1; bu = 1; cycles(100); bu = 0; cycles(300);
    // inhibit
    pm = 3'd4; inh_n = 0; cycles(200);
    sc = 1; cycles(50); sc = 0;
    inh_n = 1; cycles(400);
    finish_run();
  end
endmodule